// File: doc/BRIEF.md
# Debug Chain Selector

This block is the top-level decoder of a scan-based debug unit. It sits between the test access port and up to four debug sub-modules: memory-bus access (index 0), first CPU (index 1), second CPU (index 2) and serial port (index 3). It watches every data-register scan and treats each one in one of two ways. A scan can be a command that picks which sub-module is active. Any other scan is passed through to the sub-module that is active now.

The last bit shifted into a scan decides how the scan is treated. If that bit is 1, the two bits shifted in just before it form a module index, and the block latches that index when update is pulsed. If that bit is 0, the scan is a module operation. The block forwards the shift, capture and update strobes only to the active sub-module, and it takes the serial output from that sub-module. The selection stays in place across any number of pass-through scans, until another select command arrives or the port is reset.

Top module: `dbg_chain_sel`

## Requirements
- R1: After `trst_n` is low, no module is active: `act_valid` is 0 and all per-module strobes are 0 while the strobe inputs are idle.
- R2: A 3-bit scan, shifted in least significant bit first, whose last bit is 1, makes the index formed by its first two bits (first bit = index bit 0) active on the clock edge where `update_dr` is high. `act_valid` and `act_idx` show this in the next cycle.
- R3: A scan whose last bit is 0, made while a module is active, pulses `mod_update` only for that module's bit (bit n = module n).
- R4: `capture_dr` and `shift_dr` reach only the active module's bit of `mod_capture` and `mod_shift`. No bit is set while no module is active.
- R5: While a module is active, `tdo` equals `mod_tdo[act_idx]`.
- R6: While no module is active, `tdo` is the bit shifted in three shift cycles earlier. A capture clears this internal 3-bit shift register, so `tdo` reads 0 before three bits have been shifted.
- R7: The active module stays unchanged across pass-through scans and is changed only by an update with the flag bit set.
- R8: While no module is active, pass-through scans are ignored: no `mod_update` pulse, and `act_valid` stays 0.
- R9: A select command never produces a `mod_update` pulse on any module.
- R10: `mod_tdi` follows `tdi` at all times, broadcast to every module.
- R11: A select scan longer than three bits selects using the two bits shifted just before the final flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe from TAP |
| shift_dr | input | 1 | Shift strobe from TAP |
| update_dr | input | 1 | Update strobe from TAP |
| mod_tdo | input | 4 | Serial outputs of the sub-modules |
| tdo | output | 1 | Serial data out |
| mod_tdi | output | 1 | Serial data to the sub-modules |
| mod_capture | output | 4 | Per-module capture strobe |
| mod_shift | output | 4 | Per-module shift strobe |
| mod_update | output | 4 | Per-module update strobe |
| act_valid | output | 1 | A module is active |
| act_idx | output | 2 | Index of the active module |

## Verification
The assertions check on every cycle that:
- at most one module sees each strobe, and none does while nothing is active;
- a flagged update latches the index held below the flag;
- the selection changes only on update, and the valid flag never drops without reset;
- select commands never leak an update to a module.

Only the bench scenarios can show the rest. These are the bit order that forms the index, the three-bit delay of the unselected serial path, the serial output mux against chosen `mod_tdo` patterns, and that long select scans and pass-through scans before the first selection behave as required.

// File: rtl/dbg_chain_sel.sv
module dbg_chain_sel #(
  parameter int SEL_W = 2
) (
  input  logic                  tck,
  input  logic                  trst_n,
  input  logic                  tdi,
  input  logic                  capture_dr,
  input  logic                  shift_dr,
  input  logic                  update_dr,
  input  logic [(1<<SEL_W)-1:0] mod_tdo,
  output logic                  tdo,
  output logic                  mod_tdi,
  output logic [(1<<SEL_W)-1:0] mod_capture,
  output logic [(1<<SEL_W)-1:0] mod_shift,
  output logic [(1<<SEL_W)-1:0] mod_update,
  output logic                  act_valid,
  output logic [SEL_W-1:0]      act_idx
);
  localparam int NMOD  = 1 << SEL_W;
  localparam int CMD_W = SEL_W + 1;

  logic [CMD_W-1:0] cmd_sr;
  logic             flag;

  assign flag = cmd_sr[CMD_W-1];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         cmd_sr <= '0;
    else if (capture_dr) cmd_sr <= '0;
    else if (shift_dr)   cmd_sr <= {tdi, cmd_sr[CMD_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      act_valid <= 1'b0;
      act_idx   <= '0;
    end else if (update_dr && flag) begin
      act_valid <= 1'b1;
      act_idx   <= cmd_sr[SEL_W-1:0];
    end
  end

  for (genvar m = 0; m < NMOD; m++) begin : g_route
    logic hit;
    assign hit            = act_valid && (act_idx == SEL_W'(m));
    assign mod_capture[m] = hit && capture_dr;
    assign mod_shift[m]   = hit && shift_dr;
    assign mod_update[m]  = hit && update_dr && !flag;
  end

  assign mod_tdi = tdi;
  assign tdo     = act_valid ? mod_tdo[act_idx] : cmd_sr[0];
endmodule

// File: rtl/dbg_chain_sel_chk.sv
module dbg_chain_sel_chk #(
  parameter int SEL_W = 2
) (
  input logic                  tck,
  input logic                  trst_n,
  input logic                  update_dr,
  input logic [SEL_W:0]        cmd_sr,
  input logic [(1<<SEL_W)-1:0] mod_capture,
  input logic [(1<<SEL_W)-1:0] mod_shift,
  input logic [(1<<SEL_W)-1:0] mod_update,
  input logic                  act_valid,
  input logic [SEL_W-1:0]      act_idx
);
  p_onehot_strobes_r4: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(mod_shift) && $onehot0(mod_capture) && $onehot0(mod_update));

  p_idle_quiet_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !act_valid |-> (mod_shift == '0 && mod_capture == '0 && mod_update == '0));

  p_select_latch_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && cmd_sr[SEL_W]) |=> (act_valid && act_idx == $past(cmd_sr[SEL_W-1:0])));

  p_hold_sel_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> ($stable(act_idx) && $stable(act_valid)));

  p_valid_sticky_r7: assert property (@(posedge tck) disable iff (!trst_n)
    act_valid |=> act_valid);

  p_no_leak_r9: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_sr[SEL_W] |-> mod_update == '0);
endmodule

bind dbg_chain_sel dbg_chain_sel_chk #(.SEL_W(SEL_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .update_dr(update_dr), .cmd_sr(cmd_sr),
  .mod_capture(mod_capture), .mod_shift(mod_shift), .mod_update(mod_update),
  .act_valid(act_valid), .act_idx(act_idx)
);

// File: tb/dbg_chain_sel_tb.sv
module dbg_chain_sel_tb;
  logic       clk = 1'b0;
  logic       trst_n = 1'b0;
  logic       tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic [3:0] mod_tdo = '0;
  logic       tdo, mod_tdi, act_valid;
  logic [3:0] mod_capture, mod_shift, mod_update;
  logic [1:0] act_idx;

  int total = 0, fails = 0;
  bit done = 0;

  typedef struct { logic v; logic [1:0] idx; string req; } exp_t;
  exp_t q[$];
  logic       model_v = 1'b0;
  logic [1:0] model_idx = '0;

  always #10 clk = ~clk;

  dbg_chain_sel u_dut (
    .tck(clk), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .mod_tdo(mod_tdo),
    .tdo(tdo), .mod_tdi(mod_tdi), .mod_capture(mod_capture),
    .mod_shift(mod_shift), .mod_update(mod_update),
    .act_valid(act_valid), .act_idx(act_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sel_mask();
    return model_v ? 4'(1 << model_idx) : 4'b0000;
  endfunction

  always @(posedge clk) begin
    if (update_dr && trst_n) begin
      exp_t e;
      #5;
      if (q.size() == 0) chk("queue", 1, 0);
      else begin
        e = q.pop_front();
        chk({e.req, " valid"}, act_valid, e.v);
        chk({e.req, " idx"}, act_idx, e.idx);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    trst_n = 1'b0;
    repeat (2) @(negedge clk);
    trst_n = 1'b1;
    model_v = 1'b0;
    model_idx = '0;
    #5;
    chk("R1 valid", act_valid, 0);
    chk("R1 strobes", {mod_capture, mod_shift, mod_update}, 0);
    @(negedge clk);
  endtask

  task automatic scan(input logic [15:0] bits, input int len);
    logic flag;
    exp_t e;
    capture_dr = 1'b1;
    #5 chk("R4 capture", mod_capture, sel_mask());
    @(negedge clk);
    capture_dr = 1'b0;
    for (int k = 0; k < len; k++) begin
      shift_dr = 1'b1;
      tdi = bits[k];
      mod_tdo = 4'(k * 5 + 3);
      #5;
      chk("R4 shift", mod_shift, sel_mask());
      chk("R10 tdi", mod_tdi, bits[k]);
      if (model_v) chk("R5 tdo", tdo, mod_tdo[model_idx]);
      else chk("R6 tdo", tdo, (k >= 3) ? bits[k-3] : 1'b0);
      @(negedge clk);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    flag = bits[len-1];
    #5;
    if (flag) chk("R9 update", mod_update, 0);
    else if (model_v) chk("R3 update", mod_update, sel_mask());
    else chk("R8 update", mod_update, 0);
    if (flag) begin
      model_v = 1'b1;
      model_idx = {bits[len-2], bits[len-3]};
    end
    e.v = model_v;
    e.idx = model_idx;
    e.req = flag ? ((len > 3) ? "R11" : "R2") : (model_v ? "R7" : "R8");
    q.push_back(e);
    @(negedge clk);
    update_dr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    scan(16'b0101, 4);
    scan(16'b0_1101_0110, 9);
    scan(16'b110, 3);
    scan(16'h35, 8);
    scan(16'h0A, 7);
    scan(16'b100, 3);
    scan(16'h1C, 6);
    scan(16'b111, 3);
    scan(16'h2B, 8);
    scan(16'b101110, 6);
    scan(16'h12, 6);
    scan(16'h7F, 8);
    do_reset();
    scan(16'b0011, 5);
    scan(16'b101, 3);
    scan(16'h05, 4);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule